// File: doc/BRIEF.md
# Four-Channel DMA Engine with Shared Data Latch

This block moves 16-bit or 32-bit units between memory locations through one bus master port. It has four channels. Each channel holds a source pointer, a destination pointer, a unit count, a unit width, a pointer step mode for each side, and a trigger mode. A channel starts either as soon as it is loaded or on the next horizontal-blank pulse. Only one channel owns the bus at a time. The lowest channel number that is pending wins at every unit boundary. While any channel is pending or a unit is in flight, the processor's bus access is held off.

All channels share a single 32-bit data latch, and it holds the value most recently moved. A channel whose source lies in a region it may not read issues no read. It writes the latch instead. A word transfer from such a source writes the latch's low halfword into both halves of each word. Filling memory this way replays the final value of whichever channel ran last.

The bus port is valid/ready. A request (`bus_req_*`) stays valid and unchanged until `bus_req_ready` is sampled high at a clock edge, and the memory may hold ready low for any number of cycles. Read data returns on `bus_rsp_valid` in a later cycle. The engine always accepts a response, so it has no ready.

Top module: `dma4_shared_latch`

## Requirements
- R1: After reset `bus_req_valid`, `cpu_hold`, `ch_enabled` and `ch_done` are all low.
- R2: Units of only one channel are on the bus at a time. When several channels become pending together, the lowest-numbered one runs all of its units first, and at most one `ch_done` bit is high in any cycle.
- R3: A lower-numbered channel that becomes pending while a higher-numbered one is mid-transfer takes over at the next unit boundary. The interrupted channel resumes where it stopped once the lower-numbered channel has finished.
- R4: A channel loaded with `cfg_hblank`=0 starts at once. One loaded with `cfg_hblank`=1 issues no request until a `hblank_start` pulse arrives.
- R5: `cpu_hold` is high whenever a channel is pending or a unit is in progress, and low when every channel is idle.
- R6: A unit is 4 bytes when `cfg_wide`=1 and 2 bytes otherwise. The step codes are 2'b00 (add the unit size), 2'b01 (subtract it) and 2'b10 or 2'b11 (keep the pointer fixed). The count falls by one per unit.
- R7: Addresses below `BOOT_LIMIT` (default 0x4000) are unreadable for every channel. Addresses at or above `CART_BASE` (default 0x0800_0000) are unreadable for channel 0 only. No read request is ever issued to an unreadable source.
- R8: For an unreadable source, each unit writes the current latch value: the low halfword mirrored, for halfword units and for word units alike.
- R9: The latch is common to all channels and keeps its value after a channel finishes. A word read stores the full word. A halfword read stores the selected halfword (the lane given by address bit 1) in both halves.
- R10: After its last unit a channel pulses its `ch_done` bit for exactly one cycle. A non-repeating channel then clears its `ch_enabled` bit. A repeating channel in horizontal-blank mode stays enabled, reloads its count, keeps its pointers and waits for the next pulse.
- R11: A load with a count of zero leaves the channel disabled and issues nothing.
- R12: A request holds its address, data and direction stable while `bus_req_ready` is low. A transfer is correct under any pattern of ready stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the channel selected by `cfg_ch` |
| cfg_ch | input | 2 | Channel to load |
| cfg_src | input | 28 | Source byte address |
| cfg_dst | input | 28 | Destination byte address |
| cfg_cnt | input | 16 | Number of units |
| cfg_wide | input | 1 | 1 = 32-bit units, 0 = 16-bit units |
| cfg_src_step | input | 2 | Source step code |
| cfg_dst_step | input | 2 | Destination step code |
| cfg_hblank | input | 1 | 1 = wait for a horizontal-blank pulse |
| cfg_repeat | input | 1 | Re-arm after completion (horizontal-blank mode) |
| cfg_enable | input | 1 | Enable; 0 aborts the channel |
| hblank_start | input | 1 | One-cycle horizontal-blank start pulse |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted at this edge |
| bus_req_write | output | 1 | 1 = write, 0 = read |
| bus_req_wide | output | 1 | 1 = word access, 0 = halfword |
| bus_req_addr | output | 28 | Byte address |
| bus_req_wdata | output | 32 | Write data (halfwords mirrored) |
| bus_rsp_valid | input | 1 | Read data valid |
| bus_rsp_rdata | input | 32 | Read data word |
| cpu_hold | output | 1 | Processor held off the bus |
| ch_enabled | output | 4 | Per-channel enable state |
| ch_done | output | 4 | Per-channel completion pulse |

## Verification
The hardest case to reach is an unreadable-source fill whose value comes from a different channel. The port shows the latch only through what it writes. The stimulus therefore first runs a readable transfer on one channel and notes its last word. It then starts a second channel on a boot-region or cartridge source and checks that every destination word carries the earlier channel's low halfword, mirrored, and that no read reached the protected region. Preemption is reached by starting a long transfer on channel 3 under ready stalls. Channel 0 is loaded as soon as the first write is seen, and the order of the logged writes then shows the handover and the resume.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_READ = 2'b01,
    ST_RWAIT = 2'b10,
    ST_WRITE = 2'b11
  } eng_state_e;

  typedef enum logic [1:0] {
    STEP_INC  = 2'b00,
    STEP_DEC  = 2'b01,
    STEP_FIX  = 2'b10,
    STEP_FIX2 = 2'b11
  } step_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int ADDR_W = 28,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [CNT_W-1:0]  cfg_cnt_i,
  input  logic              cfg_wide_i,
  input  logic [1:0]        cfg_sstep_i,
  input  logic [1:0]        cfg_dstep_i,
  input  logic              cfg_hb_i,
  input  logic              cfg_rep_i,
  input  logic              cfg_en_i,
  input  logic              hblank_i,
  input  logic              unit_i,
  output logic              pending_o,
  output logic              en_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              wide_o,
  output logic              done_o
);
  import dma_pkg::*;

  logic              en_q, armed_q, hb_q, rep_q, wide_q, done_q;
  logic [1:0]        sstep_q, dstep_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q, reload_q;
  logic              cfg_go;

  function automatic logic [ADDR_W-1:0] next_ptr(
    input logic [ADDR_W-1:0] p, input logic [1:0] mode, input logic wide);
    logic [ADDR_W-1:0] sz;
    sz = wide ? ADDR_W'(4) : ADDR_W'(2);
    case (step_e'(mode))
      STEP_INC: next_ptr = p + sz;
      STEP_DEC: next_ptr = p - sz;
      default:  next_ptr = p;
    endcase
  endfunction

  assign cfg_go = cfg_en_i && (cfg_cnt_i != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; armed_q <= 1'b0; hb_q <= 1'b0; rep_q <= 1'b0;
      wide_q <= 1'b0; done_q <= 1'b0; sstep_q <= '0; dstep_q <= '0;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; reload_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        en_q     <= cfg_go;
        armed_q  <= cfg_go && !cfg_hb_i;
        hb_q     <= cfg_hb_i;
        rep_q    <= cfg_rep_i;
        wide_q   <= cfg_wide_i;
        sstep_q  <= cfg_sstep_i;
        dstep_q  <= cfg_dstep_i;
        src_q    <= cfg_src_i;
        dst_q    <= cfg_dst_i;
        cnt_q    <= cfg_cnt_i;
        reload_q <= cfg_cnt_i;
      end else begin
        if (hblank_i && en_q && hb_q) armed_q <= 1'b1;
        if (unit_i) begin
          src_q <= next_ptr(src_q, sstep_q, wide_q);
          dst_q <= next_ptr(dst_q, dstep_q, wide_q);
          if (cnt_q == CNT_W'(1)) begin
            done_q  <= 1'b1;
            armed_q <= 1'b0;
            if (rep_q && hb_q) begin
              cnt_q <= reload_q;
            end else begin
              en_q  <= 1'b0;
              cnt_q <= '0;
            end
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
      end
    end
  end

  assign pending_o = en_q && armed_q;
  assign en_o      = en_q;
  assign src_o     = src_q;
  assign dst_o     = dst_q;
  assign wide_o    = wide_q;
  assign done_o    = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);  // R10
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_i && !load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));  // R6
  AST_IDLE_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |-> !pending_o);  // R11
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic [NCH-1:0]  req_i,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = CH_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int               NCH        = 4,
  parameter int               CH_W       = 2,
  parameter int               ADDR_W     = 28,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT = 28'h000_4000,
  parameter logic [ADDR_W-1:0] CART_BASE  = 28'h800_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         any_i,
  input  logic [CH_W-1:0]              gnt_i,
  input  logic [NCH-1:0][ADDR_W-1:0]   src_i,
  input  logic [NCH-1:0][ADDR_W-1:0]   dst_i,
  input  logic [NCH-1:0]               wide_i,
  output logic [NCH-1:0]               unit_o,
  output logic                         busy_o,
  output logic                         req_valid_o,
  input  logic                         req_ready_i,
  output logic                         req_write_o,
  output logic                         req_wide_o,
  output logic [ADDR_W-1:0]            req_addr_o,
  output logic [31:0]                  req_wdata_o,
  input  logic                         rsp_valid_i,
  input  logic [31:0]                  rsp_rdata_i
);
  import dma_pkg::*;

  eng_state_e        st_q;
  logic [CH_W-1:0]   ch_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              wide_q, ok_q;
  logic [31:0]       latch_q;
  logic              grant_ok;

  always_comb begin
    grant_ok = (src_i[gnt_i] >= BOOT_LIMIT);
    if (gnt_i == '0 && src_i[gnt_i] >= CART_BASE) grant_ok = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ch_q <= '0; src_q <= '0; dst_q <= '0;
      wide_q <= 1'b0; ok_q <= 1'b0; latch_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (any_i) begin
          ch_q   <= gnt_i;
          src_q  <= src_i[gnt_i];
          dst_q  <= dst_i[gnt_i];
          wide_q <= wide_i[gnt_i];
          ok_q   <= grant_ok;
          st_q   <= grant_ok ? ST_READ : ST_WRITE;
        end
        ST_READ:  if (req_ready_i) st_q <= ST_RWAIT;
        ST_RWAIT: if (rsp_valid_i) begin
          if (wide_q)        latch_q <= rsp_rdata_i;
          else if (src_q[1]) latch_q <= {rsp_rdata_i[31:16], rsp_rdata_i[31:16]};
          else               latch_q <= {rsp_rdata_i[15:0], rsp_rdata_i[15:0]};
          st_q <= ST_WRITE;
        end
        ST_WRITE: if (req_ready_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_unit
      assign unit_o[g] = (st_q == ST_WRITE) && req_ready_i && (ch_q == CH_W'(g));
    end
  endgenerate

  assign busy_o      = (st_q != ST_IDLE);
  assign req_valid_o = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign req_write_o = (st_q == ST_WRITE);
  assign req_wide_o  = wide_q;
  assign req_addr_o  = (st_q == ST_WRITE) ? dst_q : src_q;
  assign req_wdata_o = (wide_q && ok_q) ? latch_q : {latch_q[15:0], latch_q[15:0]};

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=>
      (req_valid_o && $stable(req_addr_o) && $stable(req_write_o) && $stable(req_wdata_o)));  // R12
  AST_NO_PROTECTED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_write_o) |->
      (req_addr_o >= BOOT_LIMIT && !(ch_q == '0 && req_addr_o >= CART_BASE)));  // R7
  AST_LATCH_KEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && $past(st_q) == ST_IDLE) |-> $stable(latch_q));  // R9
endmodule

// File: rtl/dma4_shared_latch.sv
module dma4_shared_latch #(
  parameter int               NCH        = 4,
  parameter int               ADDR_W     = 28,
  parameter int               CNT_W      = 16,
  parameter logic [ADDR_W-1:0] BOOT_LIMIT = 28'h000_4000,
  parameter logic [ADDR_W-1:0] CART_BASE  = 28'h800_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_ch,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_src_step,
  input  logic [1:0]        cfg_dst_step,
  input  logic              cfg_hblank,
  input  logic              cfg_repeat,
  input  logic              cfg_enable,
  input  logic              hblank_start,
  output logic              bus_req_valid,
  input  logic              bus_req_ready,
  output logic              bus_req_write,
  output logic              bus_req_wide,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [31:0]       bus_req_wdata,
  input  logic              bus_rsp_valid,
  input  logic [31:0]       bus_rsp_rdata,
  output logic              cpu_hold,
  output logic [NCH-1:0]    ch_enabled,
  output logic [NCH-1:0]    ch_done
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]             pending, unit, wide;
  logic [NCH-1:0][ADDR_W-1:0] src_a, dst_a;
  logic                       any_pend, eng_busy;
  logic [CH_W-1:0]            gnt_idx;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chan_i (
        .clk(clk), .rst_n(rst_n),
        .load_i(cfg_we && (CH_W'(cfg_ch) == CH_W'(c))),
        .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt),
        .cfg_wide_i(cfg_wide), .cfg_sstep_i(cfg_src_step), .cfg_dstep_i(cfg_dst_step),
        .cfg_hb_i(cfg_hblank), .cfg_rep_i(cfg_repeat), .cfg_en_i(cfg_enable),
        .hblank_i(hblank_start), .unit_i(unit[c]),
        .pending_o(pending[c]), .en_o(ch_enabled[c]),
        .src_o(src_a[c]), .dst_o(dst_a[c]), .wide_o(wide[c]), .done_o(ch_done[c])
      );
    end
  endgenerate

  dma_arb #(.NCH(NCH), .CH_W(CH_W)) arb_i (
    .req_i(pending), .any_o(any_pend), .idx_o(gnt_idx)
  );

  dma_engine #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W),
               .BOOT_LIMIT(BOOT_LIMIT), .CART_BASE(CART_BASE)) eng_i (
    .clk(clk), .rst_n(rst_n), .any_i(any_pend), .gnt_i(gnt_idx),
    .src_i(src_a), .dst_i(dst_a), .wide_i(wide), .unit_o(unit), .busy_o(eng_busy),
    .req_valid_o(bus_req_valid), .req_ready_i(bus_req_ready),
    .req_write_o(bus_req_write), .req_wide_o(bus_req_wide),
    .req_addr_o(bus_req_addr), .req_wdata_o(bus_req_wdata),
    .rsp_valid_i(bus_rsp_valid), .rsp_rdata_i(bus_rsp_rdata)
  );

  assign cpu_hold = any_pend || eng_busy;

  AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_done));  // R2
  AST_HOLD_COVERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> cpu_hold);  // R5
  AST_DONE_CLEARS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ch_enabled[0]) && !$past(cfg_we)) |-> ch_done[0]);  // R10
endmodule

// File: tb/dma4_shared_latch_tb.sv
module dma4_shared_latch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [27:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_cnt = '0;
  logic        cfg_wide = 1'b0, cfg_hblank = 1'b0, cfg_repeat = 1'b0, cfg_enable = 1'b0;
  logic [1:0]  cfg_src_step = '0, cfg_dst_step = '0;
  logic        hblank_start = 1'b0;
  logic        bus_req_valid, bus_req_write, bus_req_wide;
  logic        bus_req_ready = 1'b0;
  logic [27:0] bus_req_addr;
  logic [31:0] bus_req_wdata;
  logic        bus_rsp_valid = 1'b0;
  logic [31:0] bus_rsp_rdata = '0;
  logic        cpu_hold;
  logic [3:0]  ch_enabled, ch_done;

  int nchk = 0, nfail = 0, cyc = 0;
  logic        force_stall = 1'b0;
  logic [31:0] mem [0:1023];
  logic [27:0] log_a [0:63];
  int          log_n = 0, boot_rd = 0, cart_rd = 0;
  int          done_cnt [0:3];

  always #2.5 clk = ~clk;

  dma4_shared_latch dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_src(cfg_src),
    .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_wide(cfg_wide), .cfg_src_step(cfg_src_step),
    .cfg_dst_step(cfg_dst_step), .cfg_hblank(cfg_hblank), .cfg_repeat(cfg_repeat),
    .cfg_enable(cfg_enable), .hblank_start(hblank_start), .bus_req_valid(bus_req_valid),
    .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write), .bus_req_wide(bus_req_wide),
    .bus_req_addr(bus_req_addr), .bus_req_wdata(bus_req_wdata), .bus_rsp_valid(bus_rsp_valid),
    .bus_rsp_rdata(bus_rsp_rdata), .cpu_hold(cpu_hold), .ch_enabled(ch_enabled), .ch_done(ch_done)
  );

  function automatic logic [31:0] init_val(int i);
    return {16'(16'h1000 + i), 16'(16'h2000 + i)};
  endfunction

  // memory model: word index from address bits 11:2, one-cycle read latency
  always @(posedge clk) begin
    bus_rsp_valid <= 1'b0;
    if (rst_n && bus_req_valid && bus_req_ready) begin
      if (bus_req_write) begin
        if (bus_req_wide) mem[bus_req_addr[11:2]] <= bus_req_wdata;
        else if (bus_req_addr[1]) mem[bus_req_addr[11:2]][31:16] <= bus_req_wdata[31:16];
        else mem[bus_req_addr[11:2]][15:0] <= bus_req_wdata[15:0];
        if (log_n < 64) log_a[log_n] <= bus_req_addr;
        log_n <= log_n + 1;
      end else begin
        bus_rsp_valid <= 1'b1;
        bus_rsp_rdata <= mem[bus_req_addr[11:2]];
        if (bus_req_addr < 28'h000_4000) boot_rd <= boot_rd + 1;
        if (bus_req_addr >= 28'h800_0000) cart_rd <= cart_rd + 1;
      end
    end
  end

  always @(negedge clk) begin
    cyc = cyc + 1;
    bus_req_ready = !force_stall && (cyc % 3 != 1);
    for (int i = 0; i < 4; i++) if (ch_done[i]) done_cnt[i] = done_cnt[i] + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ch(input int ch, input logic [27:0] s, input logic [27:0] d, input int n,
                         input bit w, input logic [1:0] ss, input logic [1:0] ds,
                         input bit hb, input bit rep, input bit en);
    @(negedge clk);
    cfg_ch = 2'(ch); cfg_src = s; cfg_dst = d; cfg_cnt = 16'(n); cfg_wide = w;
    cfg_src_step = ss; cfg_dst_step = ds; cfg_hblank = hb; cfg_repeat = rep;
    cfg_enable = en; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_hblank();
    @(negedge clk); hblank_start = 1'b1;
    @(negedge clk); hblank_start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while ((cpu_hold || bus_req_valid) && t < 3000) begin @(negedge clk); t++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!cpu_hold && !bus_req_valid && ch_enabled == 0 && ch_done == 0, "R1 reset state",
        {cpu_hold, bus_req_valid, ch_enabled, ch_done}, 0);
  endtask

  task automatic t_copy_word();
    int d0 = done_cnt[3];
    load_ch(3, 28'h200_0040, 28'h200_0400, 4, 1, 2'b00, 2'b00, 0, 0, 1);
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(mem[256 + k] == init_val(16 + k), "R6/R4/R12 word copy", mem[256 + k], init_val(16 + k));
    chk(ch_enabled[3] == 1'b0, "R10 enable self-clear", 32'(ch_enabled[3]), 0);
    chk(done_cnt[3] == d0 + 1, "R10 single done pulse", done_cnt[3], d0 + 1);
  endtask

  task automatic t_boot_fill();
    int b0 = boot_rd;
    logic [31:0] e = {init_val(19)[15:0], init_val(19)[15:0]};
    load_ch(1, 28'h000_0100, 28'h200_0500, 3, 1, 2'b00, 2'b00, 0, 0, 1);
    wait_idle();
    for (int k = 0; k < 3; k++)
      chk(mem[320 + k] == e, "R8/R9 boot source uses shared latch", mem[320 + k], e);
    chk(boot_rd == b0, "R7 no boot read", boot_rd, b0);
  endtask

  task automatic t_half_dec();
    logic [31:0] e0 = {init_val(24)[15:0], init_val(24)[31:16]};
    load_ch(2, 28'h200_0062, 28'h200_0600, 3, 0, 2'b01, 2'b00, 0, 0, 1);
    wait_idle();
    chk(mem[384] == e0, "R6/R9 halfword decrement lanes", mem[384], e0);
    chk(mem[385][15:0] == init_val(23)[31:16], "R6 third halfword", 32'(mem[385][15:0]),
        32'(init_val(23)[31:16]));
  endtask

  task automatic t_half_latch_fill();
    logic [31:0] e = {init_val(23)[31:16], init_val(23)[31:16]};
    load_ch(3, 28'h000_0200, 28'h200_0680, 1, 1, 2'b00, 2'b00, 0, 0, 1);
    wait_idle();
    chk(mem[416] == e, "R8/R9 halfword latch mirrored into word", mem[416], e);
  endtask

  task automatic t_cart();
    int c0;
    logic [31:0] e = {init_val(32)[15:0], init_val(32)[15:0]};
    load_ch(3, 28'h800_0080, 28'h200_0700, 1, 1, 2'b00, 2'b00, 0, 0, 1);
    wait_idle();
    chk(mem[448] == init_val(32), "R7 channel 3 reads cartridge", mem[448], init_val(32));
    c0 = cart_rd;
    load_ch(0, 28'h800_0080, 28'h200_0710, 2, 1, 2'b00, 2'b10, 0, 0, 1);
    wait_idle();
    chk(cart_rd == c0, "R7 channel 0 issues no cartridge read", cart_rd, c0);
    chk(mem[452] == e, "R8 channel 0 cartridge fill", mem[452], e);
    chk(mem[453] == init_val(453), "R6 fixed destination untouched beyond", mem[453], init_val(453));
  endtask

  task automatic t_priority();
    log_n = 0;
    load_ch(2, 28'h200_0200, 28'h200_0900, 2, 1, 2'b00, 2'b00, 1, 0, 1);
    load_ch(1, 28'h200_0220, 28'h200_0A00, 2, 1, 2'b00, 2'b00, 1, 0, 1);
    repeat (20) @(negedge clk);
    chk(log_n == 0 && !bus_req_valid, "R4 hblank mode waits", log_n, 0);
    chk(!cpu_hold, "R5 hold low while only armed", 32'(cpu_hold), 0);
    pulse_hblank();
    chk(cpu_hold, "R5 hold high once pending", 32'(cpu_hold), 1);
    wait_idle();
    chk(log_n == 4, "R2 write count", log_n, 4);
    chk(log_a[0] == 28'h200_0A00 && log_a[1] == 28'h200_0A04, "R2 lower channel first",
        32'(log_a[1]), 32'h200_0A04);
    chk(log_a[2] == 28'h200_0900 && log_a[3] == 28'h200_0904, "R2 higher channel after",
        32'(log_a[3]), 32'h200_0904);
  endtask

  task automatic t_preempt();
    int p = -1;
    log_n = 0;
    load_ch(3, 28'h200_0100, 28'h200_0B00, 8, 1, 2'b00, 2'b00, 0, 0, 1);
    while (log_n < 1) @(negedge clk);
    load_ch(0, 28'h200_0140, 28'h200_0C00, 2, 1, 2'b00, 2'b00, 0, 0, 1);
    wait_idle();
    for (int i = 0; i < 10; i++) if (p < 0 && log_a[i] == 28'h200_0C00) p = i;
    chk(p >= 1 && p <= 7, "R3 channel 0 takes over mid-transfer", p, 1);
    chk(log_a[p + 1] == 28'h200_0C04, "R3 channel 0 runs to completion", 32'(log_a[p + 1]), 32'h200_0C04);
    chk(log_a[9] == 28'h200_0B1C, "R3 channel 3 resumes", 32'(log_a[9]), 32'h200_0B1C);
    chk(mem[704 + 7] == init_val(64 + 7), "R3 resumed data", mem[711], init_val(71));
  endtask

  task automatic t_stall();
    logic [27:0] a;
    force_stall = 1'b1;
    load_ch(3, 28'h200_0300, 28'h200_0E00, 1, 1, 2'b00, 2'b00, 0, 0, 1);
    @(negedge clk);
    a = bus_req_addr;
    repeat (5) @(negedge clk);
    chk(bus_req_valid && bus_req_addr == a, "R12 request held under stall", 32'(bus_req_addr), 32'(a));
    force_stall = 1'b0;
    wait_idle();
    chk(mem[896] == init_val(192), "R12 data after stall", mem[896], init_val(192));
  endtask

  task automatic t_zero();
    log_n = 0;
    load_ch(1, 28'h200_0000, 28'h200_0F00, 0, 1, 2'b00, 2'b00, 0, 0, 1);
    repeat (10) @(negedge clk);
    chk(ch_enabled[1] == 1'b0 && log_n == 0 && !cpu_hold, "R11 zero count ignored",
        {ch_enabled, 28'(log_n)}, 0);
  endtask

  task automatic t_repeat();
    int d0 = done_cnt[2];
    log_n = 0;
    load_ch(2, 28'h200_0180, 28'h200_0D00, 2, 1, 2'b00, 2'b00, 1, 1, 1);
    pulse_hblank();
    wait_idle();
    chk(log_n == 2 && done_cnt[2] == d0 + 1, "R10 repeat first burst", log_n, 2);
    chk(ch_enabled[2] == 1'b1, "R10 repeat stays enabled", 32'(ch_enabled[2]), 1);
    pulse_hblank();
    wait_idle();
    chk(log_n == 4 && log_a[3] == 28'h200_0D0C, "R10 repeat continues pointers", 32'(log_a[3]), 32'h200_0D0C);
    chk(mem[835] == init_val(99), "R10 repeat data", mem[835], init_val(99));
    load_ch(2, 28'h200_0180, 28'h200_0D00, 2, 1, 2'b00, 2'b00, 1, 1, 0);
    chk(ch_enabled[2] == 1'b0, "R10 disabled by load", 32'(ch_enabled[2]), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = init_val(i);
    for (int i = 0; i < 4; i++) done_cnt[i] = 0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_copy_word();
    t_boot_fill();
    t_half_dec();
    t_half_latch_fill();
    t_cart();
    t_priority();
    t_preempt();
    t_stall();
    t_zero();
    t_repeat();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule